// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protection Controller

This block keeps the small control state of a serial EEPROM: the write enable latch, the two block protect bits that select how much of the upper array is read-only, and the enable bit that lets the external protect pin lock the status register. The command decoder gives it one-cycle requests to set or clear the latch, or to load the status register from a data byte. The write engine gives it a busy flag. The block returns the status byte that a status read shifts out. It also returns two permission signals: one says whether an array write to the presented address may start, the other whether a status write may start.

The permission outputs are combinational from the held state and the present inputs. The decoder can therefore sample them in the same cycle it finishes collecting an address or a command. Completion of any internal write cycle is seen as the busy flag falling, and that event drops the write enable latch. The nonvolatile bits take their reset values from parameters, which stand in for their stored contents at power-up.

Top module: `eeprom_stsreg`

## Requirements
- R1: While idle, the status byte reads bit 7 = protect-pin enable, bits 6..4 = 0, bits 3..2 = block protect code, bit 1 = write enable latch, bit 0 = 0 (bit 0 is the busy flag).
- R2: While `busy_i` is 1, the status byte reads 0xFF.
- R3: After reset, the write enable latch is 0, the protect-pin enable equals `WPEN_RST` (default 0) and the block protect code equals `BP_RST` (default 00).
- R4: When idle, a set request sets the latch. A clear request clears it whatever the protect pin level. When both arrive together, the clear wins.
- R5: While `busy_i` is 1, set, clear and status-write requests have no effect.
- R6: The cycle in which `busy_i` falls clears the write enable latch. This takes priority over any request in that cycle.
- R7: Protect code 00 protects nothing. Code 01 protects addresses whose two top bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address.
- R8: `array_wr_ok_o` is 1 exactly when the latch is set, `busy_i` is 0 and `addr_i` is not protected.
- R9: The hardware lock is active when `wp_n_i` is 0 and the protect-pin enable is 1. `stat_wr_ok_o` is 1 exactly when the latch is set, `busy_i` is 0 and the lock is inactive.
- R10: An accepted status write loads only data bits 7, 3 and 2. A status write is ignored when `stat_wr_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wel_set_i | input | 1 | One-cycle request to set the write enable latch |
| wel_clr_i | input | 1 | One-cycle request to clear the write enable latch |
| stat_wr_i | input | 1 | One-cycle request to load the status register |
| stat_data_i | input | 8 | Data byte for a status load |
| wp_n_i | input | 1 | External write protect pin, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| addr_i | input | ADDR_W | Candidate array write address |
| status_o | output | 8 | Status byte for reads |
| array_wr_ok_o | output | 1 | Array write to `addr_i` permitted |
| stat_wr_ok_o | output | 1 | Status write permitted |

## Verification
The address decoder is tried with a vector table that walks every protect code across addresses on both sides of each region edge: just below and at the three-quarter point, just below and at the halfway point, and the two array ends. A wrong edge or a swapped code shows up as a single flipped permission. The lock is tried with each of the two conditions alone and with both together, so a gate that ignores either the pin or the enable bit is caught. Requests during a busy period, and simultaneous set and clear, separate the intended priority order from its alternatives. Status writes with stray bits set in the data byte show whether the reserved and read-only positions stay untouched.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

  typedef logic [1:0] prot_code_t;

  typedef struct packed {
    logic       pin_en;
    prot_code_t code;
  } nv_state_t;

  localparam logic [7:0] BUSY_BYTE = 8'hFF;

  localparam int PIN_EN_BIT = 7;
  localparam int CODE_HI_BIT = 3;
  localparam int CODE_LO_BIT = 2;
  localparam int WEL_BIT = 1;

  // Region test on the two top address bits.
  function automatic logic region_hit(input prot_code_t code, input logic [1:0] top2);
    logic hit;
    unique case (code)
      2'b00:   hit = 1'b0;
      2'b01:   hit = top2[1] & top2[0];
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ssr_wel.sv
module ssr_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  output logic wel_o
);

  logic wel_q, wel_d, wel_en;
  logic busy_q;
  logic cycle_done;

  assign cycle_done = busy_q & ~busy_i;

  always_comb begin
    wel_d  = wel_q;
    wel_en = 1'b0;
    if (cycle_done) begin
      wel_d  = 1'b0;
      wel_en = 1'b1;
    end else if (!busy_i) begin
      if (clr_i) begin
        wel_d  = 1'b0;
        wel_en = 1'b1;
      end else if (set_i) begin
        wel_d  = 1'b1;
        wel_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (wel_en) wel_q <= wel_d;
    end
  end

  assign wel_o = wel_q;

  // R5: requests have no effect while busy
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(wel_q));

  // R4: clear request when idle drops the latch
  assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !busy_i) |=> !wel_q);

  // R6: completion of a write cycle drops the latch
  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |=> !wel_q);

endmodule

// File: rtl/ssr_nvbits.sv
module ssr_nvbits
  import stsreg_pkg::*;
#(
  parameter logic       PIN_EN_RST = 1'b0,
  parameter prot_code_t CODE_RST   = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output nv_state_t  nv_o
);

  nv_state_t nv_q, nv_d;
  logic      unused_data;

  assign unused_data = ^{data_i[6:4], data_i[1:0]};

  always_comb begin
    nv_d.pin_en = data_i[PIN_EN_BIT];
    nv_d.code   = {data_i[CODE_HI_BIT], data_i[CODE_LO_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q.pin_en <= PIN_EN_RST;
      nv_q.code   <= CODE_RST;
    end else if (we_i) begin
      nv_q <= nv_d;
    end
  end

  assign nv_o = nv_q;

  // R10: held bits change only through an accepted write
  assert_nv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(nv_q));

endmodule

// File: rtl/ssr_prot_dec.sv
module ssr_prot_dec
  import stsreg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prot_code_t        code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);

  localparam int TOP = ADDR_W - 1;

  logic [1:0] top2;
  logic       unused_low;

  generate
    if (ADDR_W > 2) begin : g_low
      assign unused_low = ^addr_i[TOP-2:0];
    end else begin : g_nolow
      assign unused_low = 1'b0;
    end
  endgenerate

  assign top2   = addr_i[TOP -: 2];
  assign prot_o = region_hit(code_i, top2);

  // R7: full-array code protects every address
  assert_all_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 2'b11) |-> prot_o);

  // R7: no-protection code never protects
  assert_none_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 2'b00) |-> !prot_o);

  // R7: lower half stays writable for partial codes
  assert_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i != 2'b11 && !addr_i[TOP]) |-> !prot_o);

endmodule

// File: rtl/ssr_fmt.sv
module ssr_fmt
  import stsreg_pkg::*;
(
  input  nv_state_t  nv_i,
  input  logic       wel_i,
  input  logic       busy_i,
  output logic [7:0] status_o
);

  logic [7:0] idle_byte;

  generate
    for (genvar b = 4; b <= 6; b++) begin : g_rsvd
      assign idle_byte[b] = 1'b0;
    end
  endgenerate

  assign idle_byte[PIN_EN_BIT]  = nv_i.pin_en;
  assign idle_byte[CODE_HI_BIT] = nv_i.code[1];
  assign idle_byte[CODE_LO_BIT] = nv_i.code[0];
  assign idle_byte[WEL_BIT]     = wel_i;
  assign idle_byte[0]           = 1'b0;

  assign status_o = busy_i ? BUSY_BYTE : idle_byte;

endmodule

// File: rtl/eeprom_stsreg.sv
module eeprom_stsreg
  import stsreg_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter logic       WPEN_RST = 1'b0,
  parameter prot_code_t BP_RST   = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              stat_wr_i,
  input  logic [7:0]        stat_data_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              array_wr_ok_o,
  output logic              stat_wr_ok_o
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       wel;
  nv_state_t  nv;
  logic       hw_lock;
  logic       addr_prot;
  logic       nv_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ssr_wel u_wel (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (wel_set_i),
    .clr_i  (wel_clr_i),
    .busy_i (busy_i),
    .wel_o  (wel)
  );

  assign hw_lock      = ~wp_n_i & nv.pin_en;
  assign stat_wr_ok_o = wel & ~busy_i & ~hw_lock;
  assign nv_we        = stat_wr_i & stat_wr_ok_o;

  ssr_nvbits #(
    .PIN_EN_RST (WPEN_RST),
    .CODE_RST   (BP_RST)
  ) u_nv (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (nv_we),
    .data_i (stat_data_i),
    .nv_o   (nv)
  );

  ssr_prot_dec #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .code_i (nv.code),
    .addr_i (addr_i),
    .prot_o (addr_prot)
  );

  assign array_wr_ok_o = wel & ~busy_i & ~addr_prot;

  ssr_fmt u_fmt (
    .nv_i     (nv),
    .wel_i    (wel),
    .busy_i   (busy_i),
    .status_o (status_o)
  );

  // R2: all-ones byte during an internal write
  assert_busy_byte_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_i |-> (status_o == 8'hFF));

  // R1: reserved bits and busy bit read zero when idle
  assert_idle_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));

  // R9: pin low with enable set refuses status writes
  assert_hw_lock_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_i && !wp_n_i && status_o[7]) |-> !stat_wr_ok_o);

  // R8: no array write while busy or without the latch
  assert_array_gate_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_i || !wel) |-> !array_wr_ok_o);

endmodule

// File: tb/tb_eeprom_stsreg.sv
module tb_eeprom_stsreg;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wel_set_i, wel_clr_i, stat_wr_i;
  logic [7:0]    stat_data_i;
  logic          wp_n_i, busy_i;
  logic [AW-1:0] addr_i;
  logic [7:0]    status_o;
  logic          array_wr_ok_o, stat_wr_ok_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  eeprom_stsreg #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
    .stat_wr_i(stat_wr_i), .stat_data_i(stat_data_i), .wp_n_i(wp_n_i),
    .busy_i(busy_i), .addr_i(addr_i), .status_o(status_o),
    .array_wr_ok_o(array_wr_ok_o), .stat_wr_ok_o(stat_wr_ok_o)
  );

  // {protect code, address, expected array permission}
  localparam logic [19:0] VEC [10] = '{
    {2'b00, 17'h1FFFF, 1'b1},
    {2'b01, 17'h00000, 1'b1},
    {2'b01, 17'h17FFF, 1'b1},
    {2'b01, 17'h18000, 1'b0},
    {2'b01, 17'h1FFFF, 1'b0},
    {2'b10, 17'h0FFFF, 1'b1},
    {2'b10, 17'h10000, 1'b0},
    {2'b10, 17'h17FFF, 1'b0},
    {2'b11, 17'h00000, 1'b0},
    {2'b11, 17'h0FFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_set();
    @(negedge clk); wel_set_i = 1'b1;
    @(negedge clk); wel_set_i = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); wel_clr_i = 1'b1;
    @(negedge clk); wel_clr_i = 1'b0;
  endtask

  task automatic do_wrst(input logic [7:0] d);
    @(negedge clk); stat_wr_i = 1'b1; stat_data_i = d;
    @(negedge clk); stat_wr_i = 1'b0; stat_data_i = 8'h00;
  endtask

  task automatic run_busy(input int n);
    @(negedge clk); busy_i = 1'b1;
    repeat (n) @(negedge clk);
    busy_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wel_set_i = 0; wel_clr_i = 0; stat_wr_i = 0;
    stat_data_i = 0; wp_n_i = 1; busy_i = 0; addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R1: reset state
    chk("R3 status", status_o, 8'h00);
    chk("R3 array_ok", {7'b0, array_wr_ok_o}, 8'h00);
    chk("R3 stat_ok", {7'b0, stat_wr_ok_o}, 8'h00);

    // R10: write without latch ignored
    do_wrst(8'h8C);
    chk("R10 no-latch write", status_o, 8'h00);

    // R4 R1: set latch
    do_set();
    chk("R4 R1 set", status_o, 8'h02);
    chk("R9 stat_ok", {7'b0, stat_wr_ok_o}, 8'h01);

    // R4: set and clear together, clear wins
    @(negedge clk); wel_set_i = 1; wel_clr_i = 1;
    @(negedge clk); wel_set_i = 0; wel_clr_i = 0;
    chk("R4 clr wins", status_o, 8'h00);

    // R10 R2 R6: status write with stray bits, busy, auto clear
    do_set();
    do_wrst(8'hFF);
    chk("R10 only 7,3,2", status_o, 8'h8E);
    @(negedge clk); busy_i = 1'b1;
    @(negedge clk);
    chk("R2 busy byte", status_o, 8'hFF);
    chk("R8 busy array", {7'b0, array_wr_ok_o}, 8'h00);
    busy_i = 1'b0;
    @(negedge clk);
    chk("R6 latch cleared", status_o, 8'h8C);

    // R9: lock needs both pin low and enable set
    wp_n_i = 1'b0;
    do_set();
    chk("R9 locked", {7'b0, stat_wr_ok_o}, 8'h00);
    do_wrst(8'h00);
    chk("R9 R10 refused write", status_o, 8'h8E);
    do_clr();
    chk("R4 clr under lock", status_o, 8'h8C);
    do_set();
    wp_n_i = 1'b1;
    @(negedge clk);
    chk("R9 pin high unlocks", {7'b0, stat_wr_ok_o}, 8'h01);
    do_wrst(8'h00);
    run_busy(3);
    chk("R10 cleared", status_o, 8'h00);
    wp_n_i = 1'b0;
    do_set();
    chk("R9 enable off unlocks", {7'b0, stat_wr_ok_o}, 8'h01);
    do_clr();
    wp_n_i = 1'b1;

    // R5: set during busy ignored
    @(negedge clk); busy_i = 1'b1;
    @(negedge clk); wel_set_i = 1'b1;
    @(negedge clk); wel_set_i = 1'b0; busy_i = 1'b0;
    @(negedge clk);
    chk("R5 set ignored", status_o, 8'h00);

    // R5: status write during busy ignored
    do_set();
    @(negedge clk); busy_i = 1'b1;
    @(negedge clk); stat_wr_i = 1'b1; stat_data_i = 8'h0C;
    @(negedge clk); stat_wr_i = 1'b0; busy_i = 1'b0;
    @(negedge clk);
    chk("R5 wrst ignored", status_o, 8'h00);

    // R6: set in done cycle loses to auto clear
    do_set();
    @(negedge clk); busy_i = 1'b1;
    @(negedge clk); busy_i = 1'b0; wel_set_i = 1'b1;
    @(negedge clk); wel_set_i = 1'b0;
    chk("R6 done priority", status_o, 8'h00);

    // R7 R8: protection table
    for (int i = 0; i < 10; i++) begin
      do_set();
      do_wrst({4'b0000, VEC[i][19:18], 2'b00});
      run_busy(2);
      addr_i = VEC[i][17:1];
      do_set();
      chk("R1 code field", {6'b0, status_o[3:2]}, {6'b0, VEC[i][19:18]});
      chk("R7 R8 array_ok", {7'b0, array_wr_ok_o}, {7'b0, VEC[i][0]});
    end

    // R8: no latch, unprotected address refused
    do_set();
    do_wrst(8'h00);
    run_busy(2);
    addr_i = '0;
    chk("R8 no latch", {7'b0, array_wr_ok_o}, 8'h00);

    // R3: reset mid-operation restores defaults
    do_set();
    do_wrst(8'h8C);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 re-reset", status_o, 8'h00);

    finish_run();
  end

endmodule